// File: doc/BRIEF.md
# Dual-Priority Request Arbiter

This block sits in front of a downstream request translator. It holds two request queues and decides which queue supplies the next request. The urgent queue carries real-time streaming reads. The background queue carries host traffic that can tolerate delay. A one-bit policy input selects how the arbiter chooses between them.

In strict policy the urgent queue always wins. An urgent request that arrives while a background request is being served takes over the downstream path in the same cycle, and the displaced background request is reissued later. In random policy the arbiter makes a weighted choice only when the request in service completes, and it never interrupts a request. A programmable weight sets how often the urgent queue wins. If the chosen queue is empty, the other queue is served instead.

Each request stays in its queue until the downstream side reports completion, so a request that is interrupted stays at the head of its queue. The block reports which queue is being served, how full each queue is, and how many cycles the oldest pending request has waited.

Top module: `dpa_arbiter`

## Requirements
- R1: After reset, `serving` is 0, both levels are 0, both input readies are 1, `oldest_age` is 0 and `iss_valid` is 0.
- R2: `serving` reads 2 while an urgent request is in service, 1 while a background request is in service and 0 when idle. The value 3 never appears. A `done` pulse during service makes `serving` read 0 after that edge.
- R3: With `policy_sel`=0 (strict), when both queues hold work at a decision point, the urgent queue is issued.
- R4: In strict policy, an urgent request that is pending while a background request is in service is issued on the next edge. On that edge `iss_valid` and `iss_abort` are both 1 and `serving` becomes 2. The interrupted background request stays queued and is later reissued with the same payload and `iss_abort`=0.
- R5: With `policy_sel`=1 (random), `iss_abort` is never raised. A request in service keeps `serving` unchanged until `done`, even when urgent work is waiting.
- R6: In random policy at a decision point with both queues non-empty, the urgent queue wins with probability `hp_alpha`/256 when `hp_alpha` is below 255. It always wins at 255. It never wins at 0. The random source advances every cycle.
- R7: In random policy, if the queue chosen by the draw is empty and the other queue is not, the other queue is issued.
- R8: `hp_level` and `lp_level` count the queued requests, including the one in service. An entry leaves its queue only on `done`. When a queue holds DEPTH entries its ready is 0 and a valid input is not accepted.
- R9: `oldest_age` is the larger of the two queue-head waiting times, counted in cycles since the head was accepted. It is 0 right after acceptance, rises by one per cycle, saturates at 2^AGE_W-1, and is 0 when both queues are empty.
- R10: A `done` pulse while `serving` is 0 changes no queue level and issues nothing.
- R11: Each issue is a single-cycle `iss_valid` pulse carrying the head payload of the chosen queue. Within a queue, requests are issued in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 1 | 0 = strict preemptive priority, 1 = weighted random choice at completion |
| hp_alpha | input | ALPHA_W | Urgent-queue weight for random policy (255 = always) |
| hp_in_valid | input | 1 | Urgent request offered |
| hp_in_ready | output | 1 | Urgent queue can accept |
| hp_in_data | input | DW | Urgent request payload |
| lp_in_valid | input | 1 | Background request offered |
| lp_in_ready | output | 1 | Background queue can accept |
| lp_in_data | input | DW | Background request payload |
| iss_valid | output | 1 | One-cycle pulse: a request is issued downstream |
| iss_data | output | DW | Payload of the issued request |
| iss_abort | output | 1 | The background request in service is cancelled by this issue |
| done | input | 1 | Downstream completed the request in service |
| serving | output | 2 | 0 idle, 1 background, 2 urgent |
| hp_level | output | $clog2(DEPTH+1) | Urgent queue occupancy |
| lp_level | output | $clog2(DEPTH+1) | Background queue occupancy |
| oldest_age | output | AGE_W | Cycles waited by the oldest queued request |

## Verification
A table drives seven arrival patterns: both queues loaded, only one queue loaded, and nothing loaded. Each pattern runs under both policies and with the weight at its extremes. These patterns separate strict priority from the forced random outcomes and from the empty-queue fallback. Directed sequences then cover an urgent arrival during background service, which must preempt in strict policy and must not in random policy. A long run with weight 128 keeps both queues busy, and the urgent share must stay near one half, which rules out a stuck or biased draw. Further sequences cover a queue filled to its limit and emptied in arrival order, waiting-time growth up to saturation, and a completion pulse while idle.

// File: rtl/dpa_pkg.sv
// Shared types for the dual-priority arbiter.
package dpa_pkg;
    // Served-queue code as seen on the status port.
    typedef enum logic [1:0] {
        SRV_NONE = 2'd0,
        SRV_LOW  = 2'd1,
        SRV_HIGH = 2'd2
    } srv_e;

    // Arbitration policy selected by the mode input.
    typedef enum logic {
        POL_STRICT = 1'b0,
        POL_RANDOM = 1'b1
    } pol_e;
endpackage

// File: rtl/dpa_req_fifo.sv
// Request queue with a per-slot waiting-time counter.
// The head entry stays in place until pop; pop happens on completion.
// Assumes the caller never pops an empty queue (it is guarded anyway).
module dpa_req_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int AGE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [DW-1:0]                in_data,
    input  logic                         pop,
    output logic [DW-1:0]                head_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic [AGE_W-1:0]             head_age,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0]    FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
    localparam logic [AGE_W-1:0] AGE_MAX  = {AGE_W{1'b1}};

    logic [DW-1:0]    slot_data [DEPTH];
    logic [AGE_W-1:0] age_vec   [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    level_q;
    logic             do_push, do_pop;

    assign empty    = (level_q == '0);
    assign in_ready = (level_q != FULL_LVL);
    assign do_push  = in_valid && in_ready;
    assign do_pop   = pop && !empty;
    assign level    = level_q;
    assign head_data = slot_data[rd_ptr];
    assign head_age  = empty ? '0 : age_vec[rd_ptr];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Store accepted payloads.
    always_ff @(posedge clk) begin
        if (do_push) slot_data[wr_ptr] <= in_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    // One saturating waiting-time counter per slot.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic [AGE_W-1:0] age_r;
        // Clear on acceptance into this slot, else count up to the limit.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  age_r <= '0;
            else if (do_push && (wr_ptr == AW'(s)))      age_r <= '0;
            else if (age_r != AGE_MAX)                   age_r <= age_r + 1'b1;
        end
        assign age_vec[s] = age_r;
    end
endmodule

// File: rtl/dpa_lfsr.sv
// Free-running Galois LFSR; exposes its top OUT_W bits as a random draw.
// Assumes a maximal-length tap mask and a non-zero seed.
module dpa_lfsr #(
    parameter int           W     = 16,
    parameter int           OUT_W = 8,
    parameter logic [W-1:0] TAPS  = 16'hB400,
    parameter logic [W-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] state_q;

    // Shift one step every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
    end

    assign rnd = state_q[W-1 -: OUT_W];
endmodule

// File: rtl/dpa_pick.sv
// Combinational queue choice at a decision point.
// Strict: urgent whenever it has work. Random: weighted coin, with
// fallback to the other queue when the coin's choice is empty.
module dpa_pick #(
    parameter int ALPHA_W = 8
) (
    input  dpa_pkg::pol_e        policy,
    input  logic [ALPHA_W-1:0]   alpha,
    input  logic [ALPHA_W-1:0]   rnd,
    input  logic                 hp_has,
    input  logic                 lp_has,
    output logic                 sel_valid,
    output logic                 sel_high
);
    import dpa_pkg::*;

    logic coin_high;
    logic want_high;

    // Form the preferred queue and resolve it against availability.
    always_comb begin
        coin_high = (alpha == {ALPHA_W{1'b1}}) || (rnd < alpha);
        want_high = (policy == POL_STRICT) ? hp_has : coin_high;
        sel_valid = hp_has || lp_has;
        sel_high  = hp_has && (want_high || !lp_has);
    end
endmodule

// File: rtl/dpa_arbiter.sv
// Dual-priority request arbiter (top).
// Serves one request at a time; the served entry is popped on done.
// Strict policy lets urgent work displace background work in one cycle.
// Assumes done is only meaningful while a request is in service.
module dpa_arbiter #(
    parameter int DW      = 16,
    parameter int DEPTH   = 4,
    parameter int AGE_W   = 8,
    parameter int ALPHA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        policy_sel,
    input  logic [ALPHA_W-1:0]          hp_alpha,
    input  logic                        hp_in_valid,
    output logic                        hp_in_ready,
    input  logic [DW-1:0]               hp_in_data,
    input  logic                        lp_in_valid,
    output logic                        lp_in_ready,
    input  logic [DW-1:0]               lp_in_data,
    output logic                        iss_valid,
    output logic [DW-1:0]               iss_data,
    output logic                        iss_abort,
    input  logic                        done,
    output logic [1:0]                  serving,
    output logic [$clog2(DEPTH+1)-1:0]  hp_level,
    output logic [$clog2(DEPTH+1)-1:0]  lp_level,
    output logic [AGE_W-1:0]            oldest_age
);
    import dpa_pkg::*;

    srv_e              srv_q;
    pol_e              policy;
    logic [DW-1:0]     hp_head, lp_head;
    logic [AGE_W-1:0]  hp_age, lp_age;
    logic              hp_empty, lp_empty;
    logic              pop_hp, pop_lp;
    logic              finish, preempt, launch;
    logic              sel_valid, sel_high;
    logic [ALPHA_W-1:0] rnd;

    assign policy  = pol_e'(policy_sel);
    assign finish  = (srv_q != SRV_NONE) && done;
    assign pop_hp  = finish && (srv_q == SRV_HIGH);
    assign pop_lp  = finish && (srv_q == SRV_LOW);
    assign preempt = (policy == POL_STRICT) && (srv_q == SRV_LOW) && !done && !hp_empty;
    assign launch  = (srv_q == SRV_NONE) && sel_valid;

    dpa_req_fifo #(.DW(DW), .DEPTH(DEPTH), .AGE_W(AGE_W)) hp_q_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(hp_in_valid), .in_ready(hp_in_ready), .in_data(hp_in_data),
        .pop(pop_hp), .head_data(hp_head), .level(hp_level),
        .head_age(hp_age), .empty(hp_empty)
    );

    dpa_req_fifo #(.DW(DW), .DEPTH(DEPTH), .AGE_W(AGE_W)) lp_q_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(lp_in_valid), .in_ready(lp_in_ready), .in_data(lp_in_data),
        .pop(pop_lp), .head_data(lp_head), .level(lp_level),
        .head_age(lp_age), .empty(lp_empty)
    );

    dpa_lfsr #(.W(16), .OUT_W(ALPHA_W)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    dpa_pick #(.ALPHA_W(ALPHA_W)) pick_i (
        .policy(policy), .alpha(hp_alpha), .rnd(rnd),
        .hp_has(!hp_empty), .lp_has(!lp_empty),
        .sel_valid(sel_valid), .sel_high(sel_high)
    );

    // Service state and downstream issue pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srv_q     <= SRV_NONE;
            iss_valid <= 1'b0;
            iss_abort <= 1'b0;
            iss_data  <= '0;
        end else begin
            iss_valid <= 1'b0;
            iss_abort <= 1'b0;
            if (finish) begin
                srv_q <= SRV_NONE;
            end else if (preempt) begin
                srv_q     <= SRV_HIGH;
                iss_valid <= 1'b1;
                iss_abort <= 1'b1;
                iss_data  <= hp_head;
            end else if (launch) begin
                srv_q     <= sel_high ? SRV_HIGH : SRV_LOW;
                iss_valid <= 1'b1;
                iss_data  <= sel_high ? hp_head : lp_head;
            end
        end
    end

    assign serving    = srv_q;
    assign oldest_age = (hp_age > lp_age) ? hp_age : lp_age;
endmodule

// File: rtl/dpa_arbiter_chk.sv
// Property checker for dpa_arbiter, bound to every instance.
module dpa_arbiter_chk #(
    parameter int DEPTH = 4,
    parameter int AGE_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        policy_sel,
    input logic                        hp_in_ready,
    input logic                        lp_in_ready,
    input logic                        iss_valid,
    input logic                        iss_abort,
    input logic                        done,
    input logic [1:0]                  serving,
    input logic [$clog2(DEPTH+1)-1:0]  hp_level,
    input logic [$clog2(DEPTH+1)-1:0]  lp_level,
    input logic [AGE_W-1:0]            oldest_age
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        serving != 2'd3);

    a_r2_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (serving != 2'd0 && done) |=> (serving == 2'd0));

    a_r3_strict_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !$past(policy_sel) && $past(hp_level) != '0) |-> (serving == 2'd2));

    a_r4_abort_displaces_low: assert property (@(posedge clk) disable iff (!rst_n)
        iss_abort |-> (iss_valid && serving == 2'd2 && $past(serving) == 2'd1));

    a_r5_random_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $past(policy_sel) |-> !iss_abort);

    a_r8_hp_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_level == FULL_LVL) |-> !hp_in_ready);

    a_r8_lp_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_level == FULL_LVL) |-> !lp_in_ready);

    a_r9_idle_age_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_level == '0 && lp_level == '0) |-> (oldest_age == '0));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && serving == 2'd2) |=> !iss_valid);
endmodule

bind dpa_arbiter dpa_arbiter_chk #(.DEPTH(DEPTH), .AGE_W(AGE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
    .hp_in_ready(hp_in_ready), .lp_in_ready(lp_in_ready),
    .iss_valid(iss_valid), .iss_abort(iss_abort), .done(done),
    .serving(serving), .hp_level(hp_level), .lp_level(lp_level),
    .oldest_age(oldest_age)
);

// File: tb/dpa_arbiter_tb_top.sv
module dpa_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int AGE_W = 8;
    localparam int CW = $clog2(DEPTH + 1);

    // {policy, alpha[7:0], n_urgent[2:0], n_background[2:0], expected serving[1:0]}
    localparam int NV = 7;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'd0,   3'd1, 3'd1, 2'd2},
        {1'b0, 8'd0,   3'd0, 3'd2, 2'd1},
        {1'b1, 8'd0,   3'd1, 3'd1, 2'd1},
        {1'b1, 8'd255, 3'd1, 3'd1, 2'd2},
        {1'b1, 8'd0,   3'd2, 3'd0, 2'd2},
        {1'b1, 8'd255, 3'd0, 3'd1, 2'd1},
        {1'b0, 8'd0,   3'd0, 3'd0, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic policy_sel;
    logic [7:0] hp_alpha;
    logic hp_in_valid, hp_in_ready, lp_in_valid, lp_in_ready;
    logic [DW-1:0] hp_in_data, lp_in_data, iss_data;
    logic iss_valid, iss_abort, done;
    logic [1:0] serving;
    logic [CW-1:0] hp_level, lp_level;
    logic [AGE_W-1:0] oldest_age;

    int checks = 0;
    int failures = 0;
    int iss_cnt = 0;
    logic [DW-1:0] last_data;
    logic last_abort;
    logic [1:0] last_srv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpa_arbiter #(.DW(DW), .DEPTH(DEPTH), .AGE_W(AGE_W), .ALPHA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .hp_alpha(hp_alpha),
        .hp_in_valid(hp_in_valid), .hp_in_ready(hp_in_ready), .hp_in_data(hp_in_data),
        .lp_in_valid(lp_in_valid), .lp_in_ready(lp_in_ready), .lp_in_data(lp_in_data),
        .iss_valid(iss_valid), .iss_data(iss_data), .iss_abort(iss_abort),
        .done(done), .serving(serving), .hp_level(hp_level), .lp_level(lp_level),
        .oldest_age(oldest_age)
    );

    // Record every issue pulse, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && iss_valid) begin
            iss_cnt    = iss_cnt + 1;
            last_data  = iss_data;
            last_abort = iss_abort;
            last_srv   = serving;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hp_in_valid = 1'b0; lp_in_valid = 1'b0; done = 1'b0;
        hp_in_data = '0; lp_in_data = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic pulse_done();
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    task automatic wait_iss(input int target, input int max_cyc);
        for (int k = 0; k < max_cyc && iss_cnt < target; k++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base, n_hp, n_lp, n_max, code, hi_wins;
        policy_sel = 1'b0; hp_alpha = '0;
        do_reset();

        // R1 reset state
        chk(serving == 2'd0, "R1 serving", serving, 0);
        chk(hp_level == 0 && lp_level == 0, "R1 levels", {hp_level, lp_level}, 0);
        chk(hp_in_ready && lp_in_ready, "R1 ready", {hp_in_ready, lp_in_ready}, 3);
        chk(oldest_age == 0 && !iss_valid, "R1 age/issue", oldest_age, 0);

        // Table: R3 strict priority, R6 forced draws, R7 fallback, R2 status
        for (int v = 0; v < NV; v++) begin
            do_reset();
            policy_sel = VEC[v][16];
            hp_alpha   = VEC[v][15:8];
            n_hp = int'(VEC[v][7:5]);
            n_lp = int'(VEC[v][4:2]);
            code = int'(VEC[v][1:0]);
            n_max = (n_hp > n_lp) ? n_hp : n_lp;
            base = iss_cnt;
            for (int k = 0; k < n_max; k++) begin
                hp_in_valid = (k < n_hp); hp_in_data = 16'hA000 + 16'(k);
                lp_in_valid = (k < n_lp); lp_in_data = 16'h5000 + 16'(k);
                tick();
            end
            hp_in_valid = 1'b0; lp_in_valid = 1'b0;
            wait_iss(base + 1, 8);
            if (code == 0) begin
                chk(iss_cnt == base && serving == 0, "R2 idle no issue", serving, 0);
            end else begin
                chk(iss_cnt == base + 1, "R3/R6/R7 issued", iss_cnt - base, 1);
                chk(last_srv == 2'(code), "R3/R6/R7 chosen queue", last_srv, code);
                chk(last_data == ((code == 2) ? 16'hA000 : 16'h5000), "R11 head payload",
                    last_data, (code == 2) ? 16'hA000 : 16'h5000);
                chk(hp_level == CW'(n_hp) && lp_level == CW'(n_lp), "R8 levels hold in service",
                    {hp_level, lp_level}, {CW'(n_hp), CW'(n_lp)});
                pulse_done();
                chk(serving == 0, "R2 release after done", serving, 0);
                if (code == 2) chk(hp_level == CW'(n_hp - 1), "R8 pop on done", hp_level, n_hp - 1);
                else           chk(lp_level == CW'(n_lp - 1), "R8 pop on done", lp_level, n_lp - 1);
            end
        end

        // R4 strict preemption and reissue
        do_reset();
        policy_sel = 1'b0;
        base = iss_cnt;
        lp_in_valid = 1'b1; lp_in_data = 16'h5111; tick(); lp_in_valid = 1'b0;
        wait_iss(base + 1, 8);
        chk(last_srv == 2'd1, "R4 background first", last_srv, 1);
        hp_in_valid = 1'b1; hp_in_data = 16'hA222; tick(); hp_in_valid = 1'b0;
        wait_iss(base + 2, 8);
        chk(last_abort == 1'b1 && last_srv == 2'd2, "R4 preempt abort", {last_abort, last_srv}, 3'b110);
        chk(last_data == 16'hA222, "R4 urgent payload", last_data, 16'hA222);
        chk(lp_level == 1, "R4 displaced stays queued", lp_level, 1);
        pulse_done();
        wait_iss(base + 3, 8);
        chk(last_data == 16'h5111 && !last_abort && last_srv == 2'd1, "R4 reissue same payload",
            last_data, 16'h5111);

        // R5 random policy never interrupts
        do_reset();
        policy_sel = 1'b1; hp_alpha = 8'd255;
        base = iss_cnt;
        lp_in_valid = 1'b1; lp_in_data = 16'h5333; tick(); lp_in_valid = 1'b0;
        wait_iss(base + 1, 8);
        chk(last_srv == 2'd1, "R7 fallback to background", last_srv, 1);
        hp_in_valid = 1'b1; hp_in_data = 16'hA444; tick(); hp_in_valid = 1'b0;
        repeat (6) tick();
        chk(iss_cnt == base + 1 && serving == 2'd1, "R5 no preemption", serving, 1);
        pulse_done();
        wait_iss(base + 2, 8);
        chk(last_srv == 2'd2 && last_data == 16'hA444 && !last_abort, "R5 urgent after done",
            last_data, 16'hA444);

        // R8 full queue and R11 arrival order
        do_reset();
        policy_sel = 1'b0;
        base = iss_cnt;
        for (int k = 0; k < 5; k++) begin
            hp_in_valid = 1'b1; hp_in_data = 16'hA300 + 16'(k); tick();
        end
        hp_in_valid = 1'b0;
        chk(hp_level == CW'(DEPTH) && !hp_in_ready, "R8 full", hp_level, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            wait_iss(base + k + 1, 8);
            chk(last_data == 16'hA300 + 16'(k), "R11 arrival order", last_data, 16'hA300 + 16'(k));
            pulse_done();
        end
        chk(hp_level == 0 && hp_in_ready, "R8 drained", hp_level, 0);

        // R9 waiting time and saturation
        do_reset();
        lp_in_valid = 1'b1; lp_in_data = 16'h5555; tick(); lp_in_valid = 1'b0;
        chk(oldest_age == 0, "R9 age at accept", oldest_age, 0);
        repeat (10) tick();
        chk(oldest_age == 10, "R9 age counts", oldest_age, 10);
        repeat (300) tick();
        chk(oldest_age == 8'hFF, "R9 age saturates", oldest_age, 8'hFF);

        // R10 done while idle is ignored
        do_reset();
        base = iss_cnt;
        pulse_done();
        tick();
        chk(serving == 0 && iss_cnt == base && hp_level == 0 && lp_level == 0, "R10 idle done",
            serving, 0);
        lp_in_valid = 1'b1; lp_in_data = 16'h5666; tick(); lp_in_valid = 1'b0;
        wait_iss(base + 1, 8);
        chk(lp_level == 1, "R10 queue untouched", lp_level, 1);

        // R6 weighted draw with alpha 128
        do_reset();
        policy_sel = 1'b1; hp_alpha = 8'd128;
        base = iss_cnt;
        hi_wins = 0;
        for (int k = 0; k < 2; k++) begin
            hp_in_valid = 1'b1; hp_in_data = 16'hA700;
            lp_in_valid = 1'b1; lp_in_data = 16'h5700;
            tick();
        end
        hp_in_valid = 1'b0; lp_in_valid = 1'b0;
        for (int i = 0; i < 200; i++) begin
            wait_iss(base + i + 1, 20);
            if (last_srv == 2'd2) hi_wins++;
            pulse_done();
            if (last_srv == 2'd2) hp_in_valid = 1'b1; else lp_in_valid = 1'b1;
            tick();
            hp_in_valid = 1'b0; lp_in_valid = 1'b0;
        end
        chk(hi_wins >= 50 && hi_wins <= 150, "R6 weighted share", hi_wins, 100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule